// File: doc/BRIEF.md
# Harmonic Proportion Mixer

This block builds a composite waveform sample from a fundamental sine sample and three odd-harmonic samples: the 3rd, the 5th and the 7th. Each harmonic has its own proportion word, which is an integer percentage. The harmonic sample is multiplied by its proportion. The product is divided by one hundred, and the remainder is dropped. The three scaled terms are then added to the fundamental, which is not scaled. All arithmetic is integer. The divide by one hundred uses a constant reciprocal multiply and a shift, followed by a one-step correction, so the quotient is exact for every product the inputs can produce.

Samples arrive in two's complement with a valid strobe. The datapath is a fixed three-stage pipeline, and the strobe travels alongside the data. The output is three bits wider than a sample, so four full-scale terms never overflow. The output register loads only when a valid result reaches it, so the last composite stays visible between results.

Top module: `harmonic_mixer`

## Requirements
- R1: When the valid strobe is high, the composite equals fund + q(h3,p3) + q(h5,p5) + q(h7,p7), where q(h,p) is h*p/100 truncated toward zero.
- R2: Each proportion word is a 7-bit unsigned integer, legal from 0 to 100. It scales only its own harmonic: prop3 weights harm3, prop5 weights harm5 and prop7 weights harm7.
- R3: When a product is negative, its scaled term truncates toward zero. For example, -150 at proportion 1 gives -1, and -1 at proportion 99 gives 0.
- R4: The divide by one hundred is exact at every product magnitude, including just below, at and just above multiples of 100, and at the full-scale magnitude.
- R5: A proportion of 0 removes its harmonic from the sum. A proportion of 100 adds the harmonic unchanged.
- R6: The latency is exactly 3 clock cycles. out_valid equals in_valid delayed by 3 cycles.
- R7: out_sample is SAMPLE_W+3 bits wide. All four terms at full scale (-2048 or 2047 at proportion 100) give -8192 or 8188 without wrap.
- R8: While rst_n is low, out_valid is 0 and out_sample is 0.
- R9: While out_valid is low, out_sample holds the last composite, or 0 if no composite has been produced since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input samples are valid this cycle |
| fund_in | input | SAMPLE_W | Fundamental sample, signed |
| harm3_in | input | SAMPLE_W | 3rd harmonic sample, signed |
| harm5_in | input | SAMPLE_W | 5th harmonic sample, signed |
| harm7_in | input | SAMPLE_W | 7th harmonic sample, signed |
| prop3_in | input | PROP_W | Percentage weight for the 3rd harmonic |
| prop5_in | input | PROP_W | Percentage weight for the 5th harmonic |
| prop7_in | input | PROP_W | Percentage weight for the 7th harmonic |
| out_valid | output | 1 | Composite sample is valid |
| out_sample | output | SAMPLE_W+3 | Composite sample, signed |

## Verification
The assertions assume that every proportion word presented with a high valid strobe lies between 0 and 100. The overflow bound on each scaled term, and so the output width, depends on that limit. The stimulus draws proportions only from that range, whether random or directed. It draws samples from the full two's-complement range, including the most negative code. The valid strobe is toggled at random, so that the hold behaviour and the delay of the strobe are both exercised.

// File: rtl/harmonic_mixer.sv
module harmonic_mixer #(
  parameter int SAMPLE_W = 12,
  parameter int PROP_W   = 7,
  parameter int PROP_MAX = 100
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] fund_in,
  input  logic signed [SAMPLE_W-1:0] harm3_in,
  input  logic signed [SAMPLE_W-1:0] harm5_in,
  input  logic signed [SAMPLE_W-1:0] harm7_in,
  input  logic [PROP_W-1:0]          prop3_in,
  input  logic [PROP_W-1:0]          prop5_in,
  input  logic [PROP_W-1:0]          prop7_in,
  output logic                       out_valid,
  output logic signed [SAMPLE_W+2:0] out_sample
);
  localparam int MAG_W = SAMPLE_W + PROP_W - 1;
  localparam int SH    = MAG_W + 7;
  localparam int EW    = MAG_W + SH;
  localparam int QW    = MAG_W - 6;
  localparam int OUT_W = SAMPLE_W + 3;
  localparam logic [SH-1:0] RECIP = SH'((64'd1 << SH) / 64'd100);
  localparam logic [QW:0]   QMAX  = (QW+1)'(((64'd1 << (SAMPLE_W-1)) * 64'(PROP_MAX)) / 64'd100);

  logic signed [SAMPLE_W-1:0] hs [3];
  logic [PROP_W-1:0]          ps [3];
  assign hs[0] = harm3_in;
  assign hs[1] = harm5_in;
  assign hs[2] = harm7_in;
  assign ps[0] = prop3_in;
  assign ps[1] = prop5_in;
  assign ps[2] = prop7_in;

  logic [SAMPLE_W-1:0]        habs [3];
  logic [MAG_W-1:0]           prod [3];
  logic [EW-1:0]              est_full [3];
  logic [MAG_W-1:0]           rem [3];
  logic [QW:0]                qf [3];
  logic signed [OUT_W-1:0]    term [3];
  logic signed [OUT_W-1:0]    sum;

  logic [MAG_W-1:0]           s1_mag [3];
  logic [MAG_W-1:0]           s2_mag [3];
  logic [QW-1:0]              s2_est [3];
  logic                       s1_neg [3];
  logic                       s2_neg [3];
  logic signed [SAMPLE_W-1:0] s1_fund, s2_fund;
  logic                       v1, v2;

  // stage 1: magnitude product; stage 2: reciprocal estimate; stage 3: correct, sign, sum
  always_comb begin
    sum = OUT_W'(s2_fund);
    for (int i = 0; i < 3; i++) begin
      habs[i]     = hs[i][SAMPLE_W-1] ? (~hs[i] + 1'b1) : hs[i];
      prod[i]     = MAG_W'(habs[i]) * MAG_W'(ps[i]);
      est_full[i] = EW'(s1_mag[i]) * EW'(RECIP);
      rem[i]      = s2_mag[i] - MAG_W'(s2_est[i]) * MAG_W'(100);
      qf[i]       = {1'b0, s2_est[i]} + (QW+1)'(rem[i] >= MAG_W'(100));
      term[i]     = s2_neg[i] ? -signed'(OUT_W'(qf[i])) : signed'(OUT_W'(qf[i]));
      sum         = sum + term[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1         <= 1'b0;
      v2         <= 1'b0;
      out_valid  <= 1'b0;
      out_sample <= '0;
      s1_fund    <= '0;
      s2_fund    <= '0;
      for (int i = 0; i < 3; i++) begin
        s1_mag[i] <= '0;
        s2_mag[i] <= '0;
        s2_est[i] <= '0;
        s1_neg[i] <= 1'b0;
        s2_neg[i] <= 1'b0;
      end
    end else begin
      v1        <= in_valid;
      v2        <= v1;
      out_valid <= v2;
      s1_fund   <= fund_in;
      s2_fund   <= s1_fund;
      for (int i = 0; i < 3; i++) begin
        s1_mag[i] <= prod[i];
        s1_neg[i] <= hs[i][SAMPLE_W-1];
        s2_mag[i] <= s1_mag[i];
        s2_est[i] <= QW'(est_full[i] >> SH);
        s2_neg[i] <= s1_neg[i];
      end
      if (v2) out_sample <= sum;
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_prop_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (prop3_in <= PROP_W'(PROP_MAX) && prop5_in <= PROP_W'(PROP_MAX)
                  && prop7_in <= PROP_W'(PROP_MAX)));

  assert_est_within_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |-> (rem[0] < MAG_W'(200) && rem[1] < MAG_W'(200) && rem[2] < MAG_W'(200)));

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    age == 2'd3 |-> out_valid == $past(in_valid, 3));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |-> (qf[0] <= QMAX && qf[1] <= QMAX && qf[2] <= QMAX));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sample));
endmodule

// File: tb/test_harmonic_mixer.sv
module test_harmonic_mixer;
  localparam int W  = 12;
  localparam int P  = 7;
  localparam int OW = W + 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst_n, in_valid;
  logic signed [W-1:0]  fund_in, harm3_in, harm5_in, harm7_in;
  logic [P-1:0]         prop3_in, prop5_in, prop7_in;
  logic                 out_valid;
  logic signed [OW-1:0] out_sample;

  harmonic_mixer #(.SAMPLE_W(W), .PROP_W(P), .PROP_MAX(100)) i_harmonic_mixer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .fund_in(fund_in), .harm3_in(harm3_in), .harm5_in(harm5_in), .harm7_in(harm7_in),
    .prop3_in(prop3_in), .prop5_in(prop5_in), .prop7_in(prop7_in),
    .out_valid(out_valid), .out_sample(out_sample));

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  bit    hv   [3];
  int    hval [3];
  string htag [3];
  int    last_exp = 0;

  function automatic int model(int f, int a, int b, int c, int pa, int pb, int pc);
    return f + (a * pa) / 100 + (b * pb) / 100 + (c * pc) / 100;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, int f, int a, int b, int c, int pa, int pb, int pc, string tag);
    @(negedge clk);
    if (hv[2]) last_exp = hval[2];
    check(out_valid == hv[2], "R6 valid delay", int'(out_valid), int'(hv[2]));
    check(int'(out_sample) == last_exp, hv[2] ? htag[2] : "R9 hold",
          int'(out_sample), last_exp);
    for (int k = 2; k > 0; k--) begin
      hv[k] = hv[k-1]; hval[k] = hval[k-1]; htag[k] = htag[k-1];
    end
    hv[0] = v; hval[0] = model(f, a, b, c, pa, pb, pc); htag[0] = tag;
    in_valid = v;
    fund_in  = W'(f);  harm3_in = W'(a); harm5_in = W'(b); harm7_in = W'(c);
    prop3_in = P'(pa); prop5_in = P'(pb); prop7_in = P'(pc);
  endtask

  function automatic int rs();
    return int'($urandom_range(0, 4095)) - 2048;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 3; k++) begin hv[k] = 0; hval[k] = 0; htag[k] = ""; end
    rst_n = 0; in_valid = 0;
    fund_in = '0; harm3_in = '0; harm5_in = '0; harm7_in = '0;
    prop3_in = '0; prop5_in = '0; prop7_in = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 reset valid", int'(out_valid), 0);
    check(out_sample == '0, "R8 reset sample", int'(out_sample), 0);
    rst_n = 1;

    step(1, 5, 1000, -777, 333, 100, 0, 0, "R5 full and zero weight");
    step(1, 0, 0, 555, 0, 0, 100, 0, "R5 unity weight");
    step(1, 0, -1, -150, -101, 99, 1, 100, "R3 toward zero");
    step(1, 0, -333, 0, 0, 50, 0, 0, "R3 negative half");
    step(1, 0, 100, 99, 199, 1, 1, 1, "R4 near multiples");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9 gap");
    step(1, 0, 2047, -2048, 2047, 100, 100, 99, "R4 full magnitude");
    step(1, 0, -2047, 1999, -2001, 99, 51, 49, "R4 mixed");
    step(1, -2048, -2048, -2048, -2048, 100, 100, 100, "R7 negative full scale");
    step(1, 2047, 2047, 2047, 2047, 100, 100, 100, "R7 positive full scale");
    step(1, 7, 1000, 1000, 1000, 10, 20, 30, "R2 own weights");
    step(1, 7, 1000, 1000, 1000, 30, 10, 20, "R2 rotated weights");
    step(1, -9, 1000, -1000, 500, 0, 0, 40, "R2 single weight");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9 gap");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9 gap");
    for (int n = 0; n < 4000; n++) begin
      step($urandom_range(0, 3) != 0, rs(), rs(), rs(), rs(),
           int'($urandom_range(0, 100)), int'($urandom_range(0, 100)),
           int'($urandom_range(0, 100)), "R1 random");
    end
    for (int n = 0; n < 4; n++) step(0, 0, 0, 0, 0, 0, 0, 0, "R9 flush");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule